// File: doc/BRIEF.md
# Hardware Store Request Arbiter

This block sits between a host SRAM bus and a nonvolatile backup engine. A single shared line is active low and open drain. Any party may pull it low to ask for a backup, and the block pulls it low itself to show that a backup is running. The block reads the pad level through a two-flop synchroniser. When it sees the line low, it blocks new host writes and waits a fixed grace window so that cycles already under way can finish. It then decides whether to back up at all.

A backup is started only when the SRAM has taken at least one write since the last completed backup or restore. If no write has been taken, the request is dropped. While the engine works, the block holds the line low and keeps the SRAM disabled. After the engine reports completion, the SRAM stays disabled until the line has been seen high again. If nothing drives the line, it reads high and the block stays idle.

Top module: `store_req_arbiter`

## Requirements
- R1: In reset `store_start`=0, `line_pull_low`=0, `sram_en`=1 and `wr_inhibit`=0. The synchroniser resets to the idle-high level, so a line that is already low when reset ends is first seen after two clock edges: `wr_inhibit` is still 0 after the first edge.
- R2: `wr_inhibit` goes to 1 on the second clock edge after the line goes low. A `bus_wr_req` presented while `wr_inhibit`=1 is ignored and does not make a later request start a backup.
- R3: A `bus_wr_req` presented while `wr_inhibit`=0 is accepted and marks the SRAM as written. This holds even in the cycle in which the pad falls, because that write was already under way.
- R4: With the SRAM written, `store_start` is a single-cycle pulse that appears exactly DELAY+3 clock edges after the line goes low, and not earlier.
- R5: With the SRAM not written, `store_start` never pulses for the request, `sram_en` stays 1 and `line_pull_low` stays 0. Once the line is released, `wr_inhibit` returns to 0 on the third edge after release.
- R6: `line_pull_low` and `sram_en`=0 hold from the `store_start` cycle up to and including the edge at which `store_done`=1 is sampled. After that edge, `line_pull_low` is 0.
- R7: After a backup completes, `sram_en` stays 0 while the line stays low. It returns to 1, with `wr_inhibit`=0, on the third edge after the line goes high, and not on the second.
- R8: A `store_done` pulse clears the written mark. A following request with no accepted write in between starts no backup.
- R9: A `recall_done` pulse clears the written mark. If an accepted write falls in the same cycle, the write wins and the mark stays set.
- R10: `line_pull_low` follows `other_store_busy` in the same cycle, so a backup started by another source also holds the line low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_i | input | 1 | Sampled pad level of the shared request/busy line (1 = idle) |
| bus_wr_req | input | 1 | Host write cycle request, one cycle per write |
| recall_done | input | 1 | One-cycle pulse: a restore from nonvolatile memory finished |
| other_store_busy | input | 1 | A backup started by another source is running |
| store_done | input | 1 | One-cycle pulse from the engine: the backup finished |
| store_start | output | 1 | One-cycle pulse to the engine: begin a backup |
| line_pull_low | output | 1 | Open-drain enable: 1 drives the shared line low |
| sram_en | output | 1 | SRAM enabled for host access |
| wr_inhibit | output | 1 | New host writes are blocked |

## Verification
Directed requests are made in four situations: with no write since the last transfer, with a write placed exactly on the falling cycle, with the mark cleared by a restore, and with a write and a restore in the same cycle. Each pair tells a conditional start apart from an unconditional one and shows which event wins. Random rounds vary the writes before the request, the writes tried inside the grace window, restore pulses, engine latency and how long the line stays low after completion. These rounds separate accepted writes from blocked ones and check the lockout length against the release time. A backup from another source checks the line drive that does not come from this block. It also checks that its completion leaves the SRAM clean.

// File: rtl/sra_pkg.sv
// Shared types of the store request arbiter.
// Assumes: nothing beyond IEEE 1800-2017.
package sra_pkg;

    typedef enum logic [2:0] {
        ARB_IDLE,   // line high, host traffic free
        ARB_GRACE,  // line seen low, grace window running
        ARB_START,  // issue the start pulse to the engine
        ARB_WAIT,   // backup running, line held low
        ARB_LOCK,   // backup over, SRAM kept off until line high
        ARB_DROP    // request dropped (clean), wait for line high
    } arb_state_t;

endpackage

// File: rtl/sra_sync.sv
// Multi-flop level synchroniser for an asynchronous pad input.
// Assumes: the input level is quasi-static against the clock; the
// reset value of every stage is RESET_VAL, so an undriven pad looks idle.
module sra_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] shift_q;

    // Shift the pad level through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) shift_q <= {STAGES{RESET_VAL}};
        else        shift_q <= {shift_q[STAGES-2:0], d};
    end

    assign q = shift_q[STAGES-1];

endmodule

// File: rtl/sra_grace_timer.sv
// Grace window counter: counts while run is high and flags the last
// cycle of a DELAY-cycle window; clears whenever run is low.
// Assumes: DELAY >= 1; run stays high until expired has been seen.
module sra_grace_timer #(
    parameter int DELAY = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    localparam int CW = (DELAY > 1) ? $clog2(DELAY) : 1;
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    logic [CW-1:0] cnt_q;

    // Count cycles spent inside the window, restart when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (!run)              cnt_q <= '0;
        else if (cnt_q != LAST)     cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == LAST);

    // R4: window counter never passes the last cycle of the window.
    a_r4_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (int'(cnt_q) <= DELAY - 1));

endmodule

// File: rtl/sra_dirty.sv
// Written-since-last-transfer mark: set by an accepted host write,
// cleared by a finished backup or restore; a write in the same cycle wins.
// Assumes: done pulses are one cycle wide.
module sra_dirty (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_accept,
    input  logic xfer_done,
    output logic dirty
);

    // Hold the written mark between transfers.
    always_ff @(posedge clk) begin
        if (!rst_n)          dirty <= 1'b0;
        else if (wr_accept)  dirty <= 1'b1;
        else if (xfer_done)  dirty <= 1'b0;
    end

endmodule

// File: rtl/store_req_arbiter.sv
// Store request arbiter for a shared active-low open-drain request/busy
// line. Samples the line, blocks new writes, runs a grace window, starts
// a backup only if the SRAM was written, drives the line low while a
// backup runs and locks the SRAM until the line is seen high again.
// Assumes: line_i is the pad level (wired-AND of all drivers, pulled up);
// store_done arrives only after store_start or while other_store_busy.
module store_req_arbiter
    import sra_pkg::*;
#(
    parameter int DELAY       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    input  logic bus_wr_req,
    input  logic recall_done,
    input  logic other_store_busy,
    input  logic store_done,
    output logic store_start,
    output logic line_pull_low,
    output logic sram_en,
    output logic wr_inhibit
);

    arb_state_t state_q, state_d;
    logic       line_s;
    logic       grace_exp;
    logic       dirty;
    logic       wr_accept;
    logic       own_busy;

    sra_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (line_i),
        .q     (line_s)
    );

    sra_grace_timer #(.DELAY(DELAY)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (state_q == ARB_GRACE),
        .expired (grace_exp)
    );

    sra_dirty u_dirty (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_accept (wr_accept),
        .xfer_done (store_done || recall_done),
        .dirty     (dirty)
    );

    // Next-state selection for the request sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:  if (!line_s)   state_d = ARB_GRACE;
            ARB_GRACE: if (grace_exp) state_d = dirty ? ARB_START : ARB_DROP;
            ARB_START:                state_d = ARB_WAIT;
            ARB_WAIT:  if (store_done) state_d = ARB_LOCK;
            ARB_LOCK:  if (line_s)    state_d = ARB_IDLE;
            ARB_DROP:  if (line_s)    state_d = ARB_IDLE;
            default:                  state_d = ARB_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    // Output decode from the registered state and synchronised line.
    always_comb begin
        own_busy      = (state_q == ARB_START) || (state_q == ARB_WAIT);
        store_start   = (state_q == ARB_START);
        line_pull_low = own_busy || other_store_busy;
        sram_en       = !(own_busy || (state_q == ARB_LOCK));
        wr_inhibit    = !line_s || (state_q != ARB_IDLE);
        wr_accept     = bus_wr_req && !wr_inhibit;
    end

    // R5: a backup is only launched while the written mark is set.
    a_r5_start_needs_dirty: assert property (@(posedge clk) disable iff (!rst_n)
        store_start |-> dirty);

    // R4: the start request is exactly one cycle wide.
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        store_start |=> !store_start);

    // R6: the line is held low once the engine has been started.
    a_r6_pull_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        store_start |=> line_pull_low);

    // R2: a blocked write never sets the written mark.
    a_r2_blocked_write_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_inhibit && !dirty) |=> !dirty);

    // R7: a disabled SRAM stays disabled while the line still reads low.
    a_r7_lock_until_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_en && !line_s) |=> !sram_en);

    // R10: a foreign backup always drives the line low.
    a_r10_foreign_drive: assert property (@(posedge clk) disable iff (!rst_n)
        other_store_busy |-> line_pull_low);

endmodule

// File: tb/store_req_arbiter_test.sv
// Self-checking bench: directed corner cases plus seeded random rounds.
module store_req_arbiter_test;

    localparam int DLY = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_low = 1'b0;
    logic bus_wr_req = 1'b0;
    logic recall_done = 1'b0;
    logic other_store_busy = 1'b0;
    logic store_done = 1'b0;
    logic store_start, line_pull_low, sram_en, wr_inhibit;
    logic line_i;

    int checks = 0;
    int errors = 0;
    bit model_dirty = 1'b0;

    // Wired-AND pad with pull-up: low if anyone drives it.
    assign line_i = !(ext_low || line_pull_low);

    always #10 clk = ~clk;

    store_req_arbiter #(.DELAY(DLY)) uut (
        .clk(clk), .rst_n(rst_n), .line_i(line_i), .bus_wr_req(bus_wr_req),
        .recall_done(recall_done), .other_store_busy(other_store_busy),
        .store_done(store_done), .store_start(store_start),
        .line_pull_low(line_pull_low), .sram_en(sram_en), .wr_inhibit(wr_inhibit)
    );

    function automatic int exp_start_edges(int d);
        return d + 3;
    endfunction

    function automatic bit exp_store(bit dirty_mark);
        return dirty_mark;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One clock: pass a falling edge, then settle one time unit.
    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic host_write();
        bus_wr_req = 1'b1;
        if (!wr_inhibit) model_dirty = 1'b1;
        step();
        bus_wr_req = 1'b0;
    endtask

    // Full request round; wr_at_fall puts a write on the falling cycle,
    // grace_wr tries writes inside the blocked part of the window.
    task automatic request(input bit wr_at_fall, input bit grace_wr,
                           input int lat, input int hold);
        bit exp;
        ext_low = 1'b1;
        if (wr_at_fall) begin
            bus_wr_req = 1'b1;
            model_dirty = 1'b1;                            // R3 accepted
        end
        step();
        bus_wr_req = 1'b0;
        chk(wr_inhibit == 1'b0, "R2", wr_inhibit, 0);
        step();
        chk(wr_inhibit == 1'b1, "R2", wr_inhibit, 1);
        for (int i = 2; i < exp_start_edges(DLY) - 1; i++) begin
            bus_wr_req = grace_wr && ($urandom_range(0, 1) == 1);
            step();
            bus_wr_req = 1'b0;
        end
        chk(store_start == 1'b0, "R4", store_start, 0);
        step();
        exp = exp_store(model_dirty);
        chk(store_start == exp, exp ? "R4" : "R5", store_start, exp);
        if (exp) begin
            chk(line_pull_low == 1'b1 && sram_en == 1'b0, "R6", line_pull_low, 1);
            step();
            chk(store_start == 1'b0, "R4", store_start, 0);
            for (int i = 1; i < lat; i++) step();
            chk(line_pull_low == 1'b1 && sram_en == 1'b0, "R6", line_pull_low, 1);
            store_done = 1'b1;
            step();
            store_done = 1'b0;
            model_dirty = 1'b0;                            // R8 cleared
            chk(line_pull_low == 1'b0, "R6", line_pull_low, 0);
            chk(sram_en == 1'b0, "R7", sram_en, 0);
            for (int i = 0; i < hold; i++) step();
            chk(sram_en == 1'b0, "R7", sram_en, 0);
            ext_low = 1'b0;
            step();
            step();
            chk(sram_en == 1'b0, "R7", sram_en, 0);
            step();
            chk(sram_en == 1'b1 && wr_inhibit == 1'b0, "R7", sram_en, 1);
        end else begin
            chk(sram_en == 1'b1 && line_pull_low == 1'b0, "R5", sram_en, 1);
            for (int i = 0; i < hold; i++) step();
            ext_low = 1'b0;
            step();
            step();
            chk(wr_inhibit == 1'b1, "R5", wr_inhibit, 1);
            step();
            chk(wr_inhibit == 1'b0, "R5", wr_inhibit, 0);
        end
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset values with the line already low.
        ext_low = 1'b1;
        repeat (3) step();
        chk(store_start == 0 && line_pull_low == 0, "R1", store_start, 0);
        chk(sram_en == 1 && wr_inhibit == 0, "R1", sram_en, 1);
        rst_n = 1'b1;
        step();
        chk(wr_inhibit == 1'b0, "R1", wr_inhibit, 0);
        step();
        chk(wr_inhibit == 1'b1, "R1", wr_inhibit, 1);
        ext_low = 1'b0;
        repeat (DLY + 8) step();
        chk(wr_inhibit == 1'b0 && store_start == 1'b0, "R1", wr_inhibit, 0);

        // R5: clean request is dropped.
        request(1'b0, 1'b0, 2, 1);
        // R2: writes inside the window are ignored.
        request(1'b0, 1'b1, 2, 0);
        // R3: write on the falling cycle counts.
        request(1'b1, 1'b0, 3, 2);
        // R8: no write since the backup, nothing started.
        request(1'b0, 1'b0, 1, 0);
        // R4: written, backup starts.
        host_write();
        request(1'b0, 1'b0, 1, 0);
        // R9: restore clears the mark.
        host_write();
        recall_done = 1'b1;
        step();
        recall_done = 1'b0;
        model_dirty = 1'b0;
        request(1'b0, 1'b0, 1, 0);
        // R9: write in the same cycle as the restore wins.
        recall_done = 1'b1;
        host_write();
        recall_done = 1'b0;
        request(1'b0, 1'b0, 2, 1);

        // R10: foreign backup drives the line; its completion cleans.
        host_write();
        other_store_busy = 1'b1;
        #1;
        chk(line_pull_low == 1'b1, "R10", line_pull_low, 1);
        repeat (3) step();
        store_done = 1'b1;
        step();
        store_done = 1'b0;
        other_store_busy = 1'b0;
        model_dirty = 1'b0;
        begin
            int seen = 0;
            for (int i = 0; i < DLY + 8; i++) begin
                step();
                if (store_start) seen++;
            end
            chk(seen == 0, "R8", seen, 0);
        end
        chk(wr_inhibit == 1'b0 && sram_en == 1'b1, "R10", wr_inhibit, 0);

        // Random rounds.
        for (int r = 0; r < 40; r++) begin
            int nwr = $urandom_range(0, 2);
            for (int k = 0; k < nwr; k++) host_write();
            if ($urandom_range(0, 3) == 0) begin
                recall_done = 1'b1;
                step();
                recall_done = 1'b0;
                model_dirty = 1'b0;
            end
            request(1'b0, 1'b1, $urandom_range(1, 5), $urandom_range(0, 4));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule